// File: doc/BRIEF.md
# ADC Register and Conversion Controller

This block is the digital front end of an analog-to-digital converter whose inputs are shared with general-purpose port pins. Software sees three byte-wide registers on a simple bus: a control/status register, a result register and a clock-configuration register. The block turns register activity into start requests and a channel number for an external converter core. It takes the core's done pulse and result byte, and it raises either a completion flag or an interrupt request.

Conversions run once or back to back. A control write or entry into stop mode throws away the conversion in flight. Leaving stop mode resumes conversion, but the first result after the exit is used only to let the analog path settle and is never reported. The converter core itself is outside the block and is reached through the start/done handshake.

Top module: `adc_ctrl`

## Requirements
- R1: After reset the control register reads 0x1F, the result and clock registers read 0x00, and `irq`, `conv_start` and `pin_sel` are low.
- R2: The register addresses are 0 for control, 1 for result and 2 for clock. Read data appears on `bus_rdata` in the cycle after `bus_rd`. In the control register, bit 7 is the completion flag, bit 6 is interrupt enable, bit 5 is continuous select and bits 4:0 are the channel. Writes to bit 7 are ignored.
- R3: A control write with a channel other than 0x1F pulses `conv_start` for one cycle, in the cycle after the write, and `conv_chan` shows the new channel. Channel 0x1F means off, and writing it issues no start.
- R4: An accepted done pulse loads `conv_result` into the result register. With interrupt enable at 0 it sets the completion flag, which stays set until the result register is read.
- R5: With interrupt enable at 1 the completion flag reads 0. An accepted done raises `irq` instead, and `irq` stays high until the result register is read.
- R6: With continuous select at 1, a new start is issued in the cycle after each accepted done. With continuous select at 0, no further start follows.
- R7: A done pulse in the same cycle as a control write is ignored: the result register and the flag are unchanged. A control write also clears the completion flag and `irq`.
- R8: While `stop_mode` is high, no start is issued, done pulses are ignored and `pin_sel` is zero.
- R9: When `stop_mode` falls, a start is issued in the next cycle if the channel is not off and either continuous select is 1 or a conversion was running when stop was entered. The first done after the exit is discarded without a flag, and another start follows it at once.
- R10: `pin_sel` is one-hot with bit n set while a conversion is running on channel n, for n below 4. Otherwise it is zero.
- R11: The clock register is read/write and drives `clk_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| stop_mode | input | 1 | Low-power stop request |
| conv_start | output | 1 | Start pulse to converter core |
| conv_chan | output | 5 | Channel select to converter core |
| conv_done | input | 1 | Conversion finished pulse |
| conv_result | input | 8 | Result byte from core |
| clk_cfg | output | 8 | Clock-configuration register value |
| pin_sel | output | 4 | One-hot routing of shared port pins to the converter |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the abort and settling cases. In one, a done pulse arrives in exactly the cycle of a control write. In the other, a conversion is in flight when stop mode is entered, and the bench must then tell the discarded settling result apart from the first real one. Directed sequences drive the done pulse on the same clock edge as the write, and they enter and leave stop mode in both continuous and single mode, including the single-mode case with no conversion pending. Random register writes with random channels, interrupt-enable values and result bytes then cover the flag, interrupt and pin-routing behaviour against a model in the bench.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int ADDR_W = 2;
  localparam int CH_W   = 5;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] A_CLK  = 2'd2;
  localparam logic [CH_W-1:0]   CH_OFF = '1;

  typedef struct packed {
    logic            ien;
    logic            cont;
    logic [CH_W-1:0] chan;
  } ctrl_t;
endpackage

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq
  import adc_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_wr,
  input  logic [CH_W-1:0] new_chan,
  input  logic [CH_W-1:0] cur_chan,
  input  logic            cur_cont,
  input  logic            stop_req,
  input  logic            done_in,
  output logic            start_o,
  output logic            busy_o,
  output logic            accept_o
);
  logic stop_q;
  logic pend_q;
  logic settle_q;
  logic resume;

  assign resume   = (cur_chan != CH_OFF) && (cur_cont || pend_q);
  assign accept_o = done_in && busy_o && !settle_q && !stop_req && !ctl_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q   <= 1'b0;
      pend_q   <= 1'b0;
      settle_q <= 1'b0;
      busy_o   <= 1'b0;
      start_o  <= 1'b0;
    end else begin
      stop_q  <= stop_req;
      start_o <= 1'b0;
      if (stop_req) begin
        if (!stop_q) pend_q <= busy_o;
        busy_o   <= 1'b0;
        settle_q <= 1'b0;
      end else if (ctl_wr) begin
        busy_o  <= (new_chan != CH_OFF);
        start_o <= (new_chan != CH_OFF);
      end else if (stop_q) begin
        pend_q <= 1'b0;
        if (resume) begin
          busy_o   <= 1'b1;
          start_o  <= 1'b1;
          settle_q <= 1'b1;
        end
      end else if (done_in && busy_o) begin
        if (settle_q) begin
          settle_q <= 1'b0;
          start_o  <= 1'b1;
        end else if (cur_cont) begin
          start_o <= 1'b1;
        end else begin
          busy_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_ctrl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              accept,
  input  logic [DW-1:0]     result,
  output logic              ctl_wr,
  output ctrl_t             ctrl_q,
  output logic [DW-1:0]     clk_q,
  output logic              coco_q,
  output logic              irq_q
);
  localparam int CW = CH_W + 2;

  logic [DW-1:0] data_q;
  logic          unused_wbit;

  assign ctl_wr      = wr && (addr == A_CTRL);
  assign unused_wbit = wdata[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '{ien: 1'b0, cont: 1'b0, chan: CH_OFF};
      data_q <= '0;
      clk_q  <= '0;
      coco_q <= 1'b0;
      irq_q  <= 1'b0;
      rdata  <= '0;
    end else begin
      if (ctl_wr) begin
        ctrl_q <= ctrl_t'(wdata[CW-1:0]);
        coco_q <= 1'b0;
        irq_q  <= 1'b0;
      end else if (accept) begin
        data_q <= result;
        if (ctrl_q.ien) irq_q  <= 1'b1;
        else            coco_q <= 1'b1;
      end else if (rd && addr == A_DATA) begin
        coco_q <= 1'b0;
        irq_q  <= 1'b0;
      end
      if (wr && addr == A_CLK) clk_q <= wdata;
      if (rd) begin
        case (addr)
          A_CTRL:  rdata <= {coco_q & ~ctrl_q.ien, ctrl_q};
          A_DATA:  rdata <= data_q;
          A_CLK:   rdata <= clk_q;
          default: rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_pin_sel.sv
module adc_pin_sel
  import adc_ctrl_pkg::*;
#(
  parameter int NPIN = 4
) (
  input  logic [CH_W-1:0] chan,
  input  logic            active,
  output logic [NPIN-1:0] sel
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign sel[i] = active && (chan == CH_W'(i));
  end
endmodule

// File: rtl/adc_ctrl.sv
module adc_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NPIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              stop_mode,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [DW-1:0]     conv_result,
  output logic [DW-1:0]     clk_cfg,
  output logic [NPIN-1:0]   pin_sel,
  output logic              irq
);
  ctrl_t ctrl_w;
  logic  ctl_wr_w;
  logic  busy_w;
  logic  accept_w;
  logic  coco_w;
  logic  ien_w;

  assign ien_w     = ctrl_w.ien;
  assign conv_chan = ctrl_w.chan;

  adc_ctrl_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .rdata(bus_rdata), .accept(accept_w),
    .result(conv_result), .ctl_wr(ctl_wr_w), .ctrl_q(ctrl_w),
    .clk_q(clk_cfg), .coco_q(coco_w), .irq_q(irq)
  );

  adc_ctrl_seq u_seq (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr_w),
    .new_chan(bus_wdata[CH_W-1:0]), .cur_chan(ctrl_w.chan),
    .cur_cont(ctrl_w.cont), .stop_req(stop_mode), .done_in(conv_done),
    .start_o(conv_start), .busy_o(busy_w), .accept_o(accept_w)
  );

  adc_pin_sel #(.NPIN(NPIN)) u_pins (
    .chan(ctrl_w.chan), .active(busy_w), .sel(pin_sel)
  );
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk
  import adc_ctrl_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NPIN = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [DW-1:0]     bus_rdata,
  input logic              stop_mode,
  input logic              conv_start,
  input logic [CH_W-1:0]   conv_chan,
  input logic              conv_done,
  input logic [NPIN-1:0]   pin_sel,
  input logic              irq,
  input logic              ien_w,
  input logic              coco_w
);
  AST_START_CHAN_ON: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> conv_chan != CH_OFF); // R3
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    stop_mode |=> !conv_start); // R8
  AST_IRQ_NEEDS_IEN: assert property (@(posedge clk) disable iff (rst)
    irq |-> ien_w); // R5
  AST_FLAG_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_CTRL && ien_w) |=> !bus_rdata[DW-1]); // R5
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_DATA && !conv_done) |=> (!irq && !coco_w)); // R4
  AST_PIN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pin_sel)); // R10
endmodule

bind adc_ctrl adc_ctrl_chk #(.DW(DW), .NPIN(NPIN)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .stop_mode(stop_mode), .conv_start(conv_start),
  .conv_chan(conv_chan), .conv_done(conv_done), .pin_sel(pin_sel),
  .irq(irq), .ien_w(ien_w), .coco_w(coco_w)
);

// File: tb/tb_adc_ctrl.sv
`timescale 1ns/1ps
module tb_adc_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       stop_mode = 1'b0, conv_start, conv_done = 1'b0, irq;
  logic [4:0] conv_chan;
  logic [7:0] conv_result = '0, clk_cfg;
  logic [3:0] pin_sel;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_ctrl dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic done(input logic [7:0] r);
    @(negedge clk); conv_result = r; conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [3:0] exp_pins(input logic [4:0] ch);
    return (ch < 5'd4) ? 4'(1 << ch) : 4'd0;
  endfunction

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    idle(4); rst = 1'b0;
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 start", conv_start, 0);
    check("R1 pins", pin_sel, 0);
    rd(2'd0, v); check("R1 ctrl", v, 8'h1F);
    rd(2'd1, v); check("R1 data", v, 8'h00);
    rd(2'd2, v); check("R1 clk", v, 8'h00);
    // R11 clock register
    wr(2'd2, 8'hA5);
    check("R11 clk_cfg", clk_cfg, 8'hA5);
    rd(2'd2, v); check("R11 readback", v, 8'hA5);
    // R3 off channel and normal start
    wr(2'd0, 8'h1F); check("R3 off no start", conv_start, 0);
    wr(2'd0, 8'h02);
    check("R3 start", conv_start, 1);
    check("R3 chan", conv_chan, 5'd2);
    check("R10 pins", pin_sel, 4'b0100);
    idle(1); check("R3 single pulse", conv_start, 0);
    // R2 bit 7 ignored
    wr(2'd0, 8'h83); check("R3 restart", conv_start, 1);
    rd(2'd0, v); check("R2 bit7 ignored", v, 8'h03);
    // R4 flag mode, R6 single
    done(8'h5A);
    check("R6 single no restart", conv_start, 0);
    check("R10 pins idle", pin_sel, 0);
    rd(2'd0, v); check("R4 flag set", v, 8'h83);
    rd(2'd0, v); check("R4 flag holds", v, 8'h83);
    rd(2'd1, v); check("R4 data", v, 8'h5A);
    rd(2'd0, v); check("R4 flag cleared", v, 8'h03);
    // R5 interrupt mode
    wr(2'd0, 8'h41);
    done(8'h33);
    check("R5 irq", irq, 1);
    rd(2'd0, v); check("R5 flag hidden", v, 8'h41);
    check("R5 irq holds", irq, 1);
    rd(2'd1, v); check("R5 data", v, 8'h33);
    check("R5 irq cleared", irq, 0);
    // R6 continuous
    wr(2'd0, 8'h21);
    done(8'h11); check("R6 cont restart", conv_start, 1);
    rd(2'd0, v); check("R6 flag", v, 8'hA1);
    done(8'h22); check("R6 cont restart 2", conv_start, 1);
    rd(2'd1, v); check("R6 data", v, 8'h22);
    wr(2'd0, 8'h1F); check("R3 stop by off", conv_start, 0);
    // R7 abort: done on the write cycle
    wr(2'd0, 8'h02);
    @(negedge clk); bus_addr = 2'd0; bus_wdata = 8'h03; bus_wr = 1'b1;
    conv_result = 8'hEE; conv_done = 1'b1;
    @(negedge clk); bus_wr = 1'b0; conv_done = 1'b0;
    check("R7 new start", conv_start, 1);
    rd(2'd0, v); check("R7 no flag", v, 8'h03);
    rd(2'd1, v); check("R7 data kept", v, 8'h22);
    done(8'h44);
    wr(2'd0, 8'h03);
    rd(2'd0, v); check("R7 write clears flag", v, 8'h03);
    done(8'h45); rd(2'd1, v); check("R4 data 2", v, 8'h45);
    // R8 / R9 stop in continuous mode
    wr(2'd0, 8'h22);
    @(negedge clk); stop_mode = 1'b1;
    idle(2);
    check("R8 pins", pin_sel, 0);
    done(8'h99);
    check("R8 no start", conv_start, 0);
    rd(2'd1, v); check("R8 done ignored", v, 8'h45);
    @(negedge clk); stop_mode = 1'b0;
    @(negedge clk);
    check("R9 resume start", conv_start, 1);
    check("R10 pins resume", pin_sel, 4'b0100);
    done(8'h77);
    check("R9 settle restart", conv_start, 1);
    rd(2'd1, v); check("R9 settle discarded", v, 8'h45);
    rd(2'd0, v); check("R9 settle no flag", v, 8'h22);
    done(8'h78);
    rd(2'd1, v); check("R9 real result", v, 8'h78);
    // R9 single mode with pending conversion
    wr(2'd0, 8'h01);
    @(negedge clk); stop_mode = 1'b1; idle(2);
    @(negedge clk); stop_mode = 1'b0; @(negedge clk);
    check("R9 pending resume", conv_start, 1);
    done(8'h10); check("R9 settle single restart", conv_start, 1);
    done(8'h12); check("R9 single ends", conv_start, 0);
    rd(2'd1, v); check("R9 single data", v, 8'h12);
    // R9 single mode idle: no resume
    @(negedge clk); stop_mode = 1'b1; idle(2);
    @(negedge clk); stop_mode = 1'b0; @(negedge clk);
    check("R9 idle no resume", conv_start, 0);
    // random mix
    for (int i = 0; i < 200; i++) begin
      logic [4:0] ch; logic ie, b7; logic [7:0] res; bit go;
      ch = 5'($urandom); ie = 1'($urandom); b7 = 1'($urandom);
      res = 8'($urandom);
      go = (ch != 5'h1F);
      wr(2'd0, {b7, ie, 1'b0, ch});
      check("R3 rnd start", conv_start, go);
      check("R10 rnd pins", pin_sel, go ? exp_pins(ch) : 4'd0);
      if (go) begin
        done(res);
        check("R5 rnd irq", irq, ie);
        rd(2'd0, v); check("R4 rnd ctrl", v, {~ie, ie, 1'b0, ch});
        rd(2'd1, v); check("R4 rnd data", v, res);
        check("R5 rnd irq clr", irq, 0);
      end else begin
        rd(2'd0, v); check("R2 rnd ctrl", v, {1'b0, ie, 1'b0, ch});
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule